// File: doc/BRIEF.md
# Slice-Based Signal Change Timestamper

The block watches a set of input lines grouped into 32-bit slices and logs each change on them. A free-running 64-bit tick counter advances once per clock. When one or more lines of an enabled slice change, the block stores one record in an internal queue. The record holds the counter value, the slice index, and the slice's 32-bit value before and after the change. All lines pass through a two-flop synchroniser before the block compares them, so the inputs may be asynchronous to the clock.

Software reads the queue through a small word-addressed register interface. It polls the occupancy, reads the head record's fields, and then issues a pop command to move on to the next record. It keeps doing this until the occupancy reads zero. A per-slice enable mask selects which slices may create records. A sticky overflow flag shows that at least one record was lost because the queue was full. With a 31.25 MHz tick clock, one counter step equals 32 ns.

Top module: `slice_stamp`

## Requirements
- R1: After reset the occupancy is 0, the overflow flag is 0, every bit of the slice enable mask is 1, and every head register reads 0.
- R2: A change on any line of an enabled slice, seen after two synchroniser flops, adds exactly one record. Several lines of one slice that change in the same cycle give a single record. Its previous field holds the slice's synchronised value from the cycle before, and its current field holds the new value.
- R3: The 64-bit tick counter grows by one every clock. Two records made from changes that lie N clocks apart carry stamps that differ by N. The stamp is read as an upper word at address 3 and a lower word at address 4.
- R4: Register map, by 3-bit word address. Address 0 is status, with the occupancy in bits [15:0] and overflow in bit 31. Address 2 is the enable mask, where bit s enables slice s. Address 5 is the source register, with the slice index in bits [23:16]. Address 6 is the previous value and address 7 is the current value.
- R5: Writing a word with bit 0 set to address 1 discards the head record and presents the next one. The same write to an empty queue changes nothing.
- R6: While the queue is empty, addresses 3 to 7 read 0.
- R7: A disabled slice creates no records. Its previous value still tracks the lines, so enabling it later creates no record until the next change, and that record's previous field is the latest value.
- R8: When several enabled slices change in the same cycle, each gets its own record with the same stamp, queued in ascending slice order.
- R9: A record that finds no free space is dropped and sets the overflow flag. Free space is measured before any pop made in the same cycle. The records already queued stay intact.
- R10: The overflow flag stays set until software writes a word with bit 31 set to address 0. A write with bit 31 clear leaves it set. A new drop in the same cycle as the clear wins.
- R11: Records leave the queue in the order they arrived, including after the storage pointers wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the tick clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | NUM_SLICES*32 | Monitored lines, slice s at bits [32s+31:32s] |
| regAddr | input | 3 | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |

## Verification
Single-slice changes with two bits flipping together show whether a simultaneous change forms one record or several. Changes on different slices ten clocks apart test the stamp arithmetic and the slice index field. Changes on two slices in the same cycle test ordering and stamp sharing. Toggles made while a slice is disabled, and then after it is enabled again, show whether the previous value was tracked. A burst of seventeen toggles into a sixteen-deep queue whose pointers have already moved covers dropping, the sticky flag and its clear, and ordering across the wrap.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int unsigned SLICE_W = 32;
  localparam int unsigned OVF_BIT = 31;
  localparam int unsigned SRC_SHIFT = 16;

  typedef enum logic [2:0] {
    ADDR_STATUS   = 3'd0,
    ADDR_CMD      = 3'd1,
    ADDR_MASK     = 3'd2,
    ADDR_STAMP_HI = 3'd3,
    ADDR_STAMP_LO = 3'd4,
    ADDR_SOURCE   = 3'd5,
    ADDR_PREV     = 3'd6,
    ADDR_CURR     = 3'd7
  } regAddr_e;

  typedef struct packed {
    logic popEn;
    logic ovfSet;
    logic ovfClr;
    logic maskWr;
  } ctrlStrobes_t;
endpackage

// File: rtl/stamp_sync.sv
module stamp_sync #(
  parameter int unsigned NUM_SLICES = 2
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NUM_SLICES*stamp_pkg::SLICE_W-1:0] rawIn,
  output logic [NUM_SLICES*stamp_pkg::SLICE_W-1:0] syncOut,
  output logic [NUM_SLICES*stamp_pkg::SLICE_W-1:0] prevOut,
  output logic [NUM_SLICES-1:0]                  changed
);
  localparam int unsigned W = stamp_pkg::SLICE_W;

  for (genvar g = 0; g < NUM_SLICES; g++) begin : gSlice
    logic [W-1:0] stage1, stage2, prevVal;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stage1  <= '0;
        stage2  <= '0;
        prevVal <= '0;
      end else begin
        stage1  <= rawIn[g*W +: W];
        stage2  <= stage1;
        prevVal <= stage2;
      end
    end

    assign syncOut[g*W +: W] = stage2;
    assign prevOut[g*W +: W] = prevVal;
    assign changed[g]        = |(stage2 ^ prevVal);
  end
endmodule

// File: rtl/stamp_ctrl.sv
module stamp_ctrl
  import stamp_pkg::*;
#(
  parameter int unsigned NUM_SLICES = 2,
  parameter int unsigned DEPTH      = 16,
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1),
  localparam int unsigned RANK_W    = $clog2(NUM_SLICES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            regAddr,
  input  logic                  regWrEn,
  input  logic                  wrBitPop,
  input  logic                  wrBitOvf,
  input  logic [NUM_SLICES-1:0] changed,
  input  logic [NUM_SLICES-1:0] enMask,
  input  logic [CNT_W-1:0]      occupancy,
  output ctrlStrobes_t          strobes,
  output logic [NUM_SLICES-1:0] accept,
  output logic [RANK_W-1:0]     slotOfs [NUM_SLICES],
  output logic [RANK_W-1:0]     pushCount
);
  int freeSlots;
  int rankRun;
  int acceptRun;
  logic [NUM_SLICES-1:0] request;

  always_comb begin
    freeSlots = int'(DEPTH) - int'(occupancy);
    rankRun   = 0;
    acceptRun = 0;
    request   = changed & enMask;
    for (int s = 0; s < NUM_SLICES; s++) begin
      slotOfs[s] = RANK_W'(rankRun);
      accept[s]  = request[s] && (rankRun < freeSlots);
      if (request[s]) rankRun = rankRun + 1;
      if (accept[s])  acceptRun = acceptRun + 1;
    end
    pushCount = RANK_W'(acceptRun);
  end

  always_comb begin
    strobes.ovfSet = |(request & ~accept);
    strobes.popEn  = regWrEn && (regAddr == ADDR_CMD) && wrBitPop && (occupancy != '0);
    strobes.ovfClr = regWrEn && (regAddr == ADDR_STATUS) && wrBitOvf;
    strobes.maskWr = regWrEn && (regAddr == ADDR_MASK);
  end

  // R7
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept & ~(changed & enMask)) == '0);
endmodule

// File: rtl/stamp_datapath.sv
module stamp_datapath
  import stamp_pkg::*;
#(
  parameter int unsigned NUM_SLICES = 2,
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned STAMP_W    = 64,
  localparam int unsigned LINES_W   = NUM_SLICES * SLICE_W,
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned RANK_W    = $clog2(NUM_SLICES + 1),
  localparam int unsigned SRC_W     = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LINES_W-1:0]    lineIn,
  input  ctrlStrobes_t          strobes,
  input  logic [NUM_SLICES-1:0] accept,
  input  logic [RANK_W-1:0]     slotOfs [NUM_SLICES],
  input  logic [RANK_W-1:0]     pushCount,
  input  logic [2:0]            regAddr,
  input  logic [31:0]           regWrData,
  output logic [NUM_SLICES-1:0] changed,
  output logic [NUM_SLICES-1:0] enMask,
  output logic [CNT_W-1:0]      occupancy,
  output logic [31:0]           regRdData
);
  logic [LINES_W-1:0] syncLines, prevLines;
  logic [STAMP_W-1:0] stampCnt;
  logic [PTR_W-1:0]   rdPtr, wrPtr;
  logic [PTR_W-1:0]   slotIdx [NUM_SLICES];
  logic               ovfFlag;

  logic [STAMP_W-1:0] memStamp [DEPTH];
  logic [SRC_W-1:0]   memSrc   [DEPTH];
  logic [SLICE_W-1:0] memPrev  [DEPTH];
  logic [SLICE_W-1:0] memCurr  [DEPTH];

  stamp_sync #(.NUM_SLICES(NUM_SLICES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   (lineIn),
    .syncOut (syncLines),
    .prevOut (prevLines),
    .changed (changed)
  );

  always_ff @(posedge clk) begin
    if (!rstN) stampCnt <= '0;
    else       stampCnt <= stampCnt + STAMP_W'(1);
  end

  always_comb begin
    for (int s = 0; s < NUM_SLICES; s++)
      slotIdx[s] = PTR_W'((int'(wrPtr) + int'(slotOfs[s])) % int'(DEPTH));
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < NUM_SLICES; s++) begin
      if (accept[s]) begin
        memStamp[slotIdx[s]] <= stampCnt;
        memSrc[slotIdx[s]]   <= SRC_W'(s);
        memPrev[slotIdx[s]]  <= prevLines[s*SLICE_W +: SLICE_W];
        memCurr[slotIdx[s]]  <= syncLines[s*SLICE_W +: SLICE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occupancy <= '0;
      ovfFlag   <= 1'b0;
      enMask    <= '1;
    end else begin
      wrPtr     <= PTR_W'((int'(wrPtr) + int'(pushCount)) % int'(DEPTH));
      if (strobes.popEn)
        rdPtr   <= PTR_W'((int'(rdPtr) + 1) % int'(DEPTH));
      occupancy <= occupancy + CNT_W'(pushCount) - CNT_W'(strobes.popEn);
      if (strobes.ovfSet)      ovfFlag <= 1'b1;
      else if (strobes.ovfClr) ovfFlag <= 1'b0;
      if (strobes.maskWr)      enMask  <= regWrData[NUM_SLICES-1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_STATUS: begin
        regRdData[CNT_W-1:0] = occupancy;
        regRdData[OVF_BIT]   = ovfFlag;
      end
      ADDR_MASK:     regRdData[NUM_SLICES-1:0] = enMask;
      ADDR_STAMP_HI: if (occupancy != '0) regRdData = memStamp[rdPtr][63:32];
      ADDR_STAMP_LO: if (occupancy != '0) regRdData = memStamp[rdPtr][31:0];
      ADDR_SOURCE:   if (occupancy != '0) regRdData[SRC_SHIFT +: SRC_W] = memSrc[rdPtr];
      ADDR_PREV:     if (occupancy != '0) regRdData = memPrev[rdPtr];
      ADDR_CURR:     if (occupancy != '0) regRdData = memCurr[rdPtr];
      default:       regRdData = '0;
    endcase
  end

  // R3
  stamp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> stampCnt == $past(stampCnt) + STAMP_W'(1));

  // R9
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CNT_W'(DEPTH));

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occupancy == CNT_W'(DEPTH)) |-> (pushCount == '0));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !strobes.ovfClr) |=> ovfFlag);

  // R5
  pop_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.popEn && pushCount == '0) |=> occupancy == $past(occupancy) - CNT_W'(1));
endmodule

// File: rtl/slice_stamp.sv
module slice_stamp
  import stamp_pkg::*;
#(
  parameter int unsigned NUM_SLICES = 2,
  parameter int unsigned DEPTH      = 16,
  localparam int unsigned LINES_W   = NUM_SLICES * SLICE_W,
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1),
  localparam int unsigned RANK_W    = $clog2(NUM_SLICES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LINES_W-1:0] lineIn,
  input  logic [2:0]         regAddr,
  input  logic               regWrEn,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData
);
  ctrlStrobes_t          strobes;
  logic [NUM_SLICES-1:0] accept, changed, enMask;
  logic [RANK_W-1:0]     slotOfs [NUM_SLICES];
  logic [RANK_W-1:0]     pushCount;
  logic [CNT_W-1:0]      occupancy;

  stamp_ctrl #(.NUM_SLICES(NUM_SLICES), .DEPTH(DEPTH)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .wrBitPop  (regWrData[0]),
    .wrBitOvf  (regWrData[OVF_BIT]),
    .changed   (changed),
    .enMask    (enMask),
    .occupancy (occupancy),
    .strobes   (strobes),
    .accept    (accept),
    .slotOfs   (slotOfs),
    .pushCount (pushCount)
  );

  stamp_datapath #(.NUM_SLICES(NUM_SLICES), .DEPTH(DEPTH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .lineIn    (lineIn),
    .strobes   (strobes),
    .accept    (accept),
    .slotOfs   (slotOfs),
    .pushCount (pushCount),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .changed   (changed),
    .enMask    (enMask),
    .occupancy (occupancy),
    .regRdData (regRdData)
  );
endmodule

// File: tb/sim_slice_stamp.sv
module sim_slice_stamp;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] lineIn = '0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  slice_stamp #(.NUM_SLICES(2), .DEPTH(16)) u0 (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); check("R1 status", d, 32'h0);
    rd(3'd2, d); check("R1 mask", d, 32'h3);
    for (int a = 3; a < 8; a++) begin
      rd(3'(a), d); check("R6 empty head", d, 32'h0);
    end
  endtask

  task automatic t_single;
    logic [31:0] d;
    @(negedge clk); lineIn[31:0] = 32'h5;
    idle(5);
    rd(3'd0, d); check("R2 one record", d, 32'h1);
    rd(3'd5, d); check("R4 source slice0", d, 32'h0);
    rd(3'd6, d); check("R2 prev", d, 32'h0);
    rd(3'd7, d); check("R2 curr", d, 32'h5);
    wr(3'd1, 32'h1);
    rd(3'd0, d); check("R5 pop", d, 32'h0);
    rd(3'd7, d); check("R6 curr empty", d, 32'h0);
  endtask

  task automatic t_stamp;
    logic [31:0] d, s1, s2;
    @(negedge clk); lineIn[8] = 1'b1;
    idle(10);
    lineIn[35] = 1'b1;
    idle(5);
    rd(3'd0, d); check("R3 two records", d, 32'h2);
    rd(3'd4, s1);
    rd(3'd3, d); check("R3 high word", d, 32'h0);
    wr(3'd1, 32'h1);
    rd(3'd4, s2);
    check("R3 stamp delta", s2 - s1, 32'd10);
    rd(3'd5, d); check("R4 source slice1", d, 32'h0001_0000);
    rd(3'd6, d); check("R4 prev slice1", d, 32'h0);
    rd(3'd7, d); check("R4 curr slice1", d, 32'h8);
    wr(3'd1, 32'h1);
  endtask

  task automatic t_pop_empty;
    logic [31:0] d;
    wr(3'd1, 32'h1);
    rd(3'd0, d); check("R5 pop empty", d, 32'h0);
  endtask

  task automatic t_both;
    logic [31:0] d, s1, s2;
    @(negedge clk); lineIn[0] = 1'b0; lineIn[33] = 1'b1;
    idle(5);
    rd(3'd0, d); check("R8 two records", d, 32'h2);
    rd(3'd5, d); check("R8 first slice0", d, 32'h0);
    rd(3'd7, d); check("R8 slice0 curr", d, 32'h104);
    rd(3'd4, s1);
    wr(3'd1, 32'h1);
    rd(3'd5, d); check("R8 second slice1", d, 32'h0001_0000);
    rd(3'd7, d); check("R8 slice1 curr", d, 32'h0A);
    rd(3'd4, s2);
    check("R8 same stamp", s2, s1);
    wr(3'd1, 32'h1);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    wr(3'd2, 32'h2);
    @(negedge clk); lineIn[1] = 1'b1;
    idle(5);
    rd(3'd0, d); check("R7 disabled no record", d, 32'h0);
    wr(3'd2, 32'h3);
    idle(5);
    rd(3'd0, d); check("R7 enable no record", d, 32'h0);
    @(negedge clk); lineIn[2] = 1'b0;
    idle(5);
    rd(3'd0, d); check("R7 record after enable", d, 32'h1);
    rd(3'd6, d); check("R7 prev tracked", d, 32'h106);
    rd(3'd7, d); check("R7 curr", d, 32'h102);
    wr(3'd1, 32'h1);
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    logic [31:0] base;
    base = lineIn[31:0];
    for (int k = 1; k <= 17; k++) begin
      @(negedge clk); lineIn[31] = ~lineIn[31];
      idle(2);
    end
    idle(5);
    rd(3'd0, d); check("R9 full with overflow", d, 32'h8000_0010);
    rd(3'd7, d); check("R9 head intact", d, base ^ 32'h8000_0000);
    wr(3'd0, 32'h0);
    rd(3'd0, d); check("R10 zero write keeps flag", d, 32'h8000_0010);
    for (int k = 1; k <= 16; k++) begin
      rd(3'd7, d);
      check("R11 order", d, (k % 2 == 1) ? (base ^ 32'h8000_0000) : base);
      wr(3'd1, 32'h1);
    end
    rd(3'd0, d); check("R10 flag stays after drain", d, 32'h8000_0000);
    wr(3'd0, 32'h8000_0000);
    rd(3'd0, d); check("R10 clear", d, 32'h0);
  endtask

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(2);
    t_reset;
    t_single;
    t_stamp;
    t_pop_empty;
    t_both;
    t_disable;
    t_overflow;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule